// File: doc/BRIEF.md
# Raster Feeder with Zero Tail

This block supplies the pixel stream that a line-buffered two-dimensional convolution engine consumes. A start pulse captures the image width, the image height and the kernel half-size. The block then passes every pixel of the frame from its input handshake port to its output stream in raster order. Once the frame is complete, it appends a run of all-zero pixels. That run is long enough for a downstream window engine to push its bottom border rows through.

The kernel is taken to be odd, with size K = 2·half + 1. The tail therefore holds width·half + 2·half + 1 zero pixels. An output holding register keeps the stream stable while the consumer stalls. A one-cycle done pulse marks the acceptance of the final zero pixel, after which the block idles until the next start.

Top module: `raster_zero_tail`

## Requirements
- R1: While reset is active and right after it is released, out_valid, in_ready and done are all low.
- R2: Exactly width·height input pixels are accepted and appear on out_data in the same order, with all 32 bits unchanged. The bits are laid out as red [7:0], green [15:8], blue [23:16] and a spare byte [31:24].
- R3: After the last frame pixel, exactly width·half + 2·half + 1 output pixels follow, each with all 32 bits zero.
- R4: No zero pixel is emitted before all frame pixels have been sent, and in_ready stays low once width·height pixels have been accepted.
- R5: While out_valid is high and out_ready is low, out_valid stays high and out_data stays stable into the next cycle.
- R6: done is high for exactly one cycle, the cycle after the final zero pixel is accepted, and at no other time.
- R7: Width, height and half-size are captured only on a start pulse in the idle state. Changing them later, or pulsing start during a run, does not change the run.
- R8: A width or height of zero accepts no input pixels and emits only the zero tail (2·half + 1 pixels when width is zero).
- R9: After done, out_valid and in_ready stay low until the next start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a frame when idle |
| img_w | input | W_W | Image width in pixels |
| img_h | input | H_W | Image height in lines |
| half_k | input | HF_W | Kernel half-size |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted when high with in_valid |
| in_data | input | PIX_W | Input pixel |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Consumer ready |
| out_data | output | PIX_W | Output pixel |
| done | output | 1 | One-cycle pulse after the last tail pixel is accepted |

## Verification
Two functions can fall in the same cycle. The last frame pixel can be accepted from the input while the holding register hands an earlier pixel to the consumer, and in that same edge the controller switches to zero generation. Full-throughput configurations, with out_ready held high, force this coincidence at every frame/tail boundary. Mixed backpressure moves it to random alignments. The bench judges the result by comparing the full output sequence against the arithmetically expected frame-then-zeros sequence and by checking that done appears only after the exact count.

// File: rtl/rzt_pkg.sv
package rzt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FRAME = 2'd1,
    ST_TAIL  = 2'd2,
    ST_DRAIN = 2'd3
  } rzt_state_e;
endpackage

// File: rtl/rzt_cnt.sv
module rzt_cnt #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          dec,
  input  logic [CW-1:0] load_val,
  output logic          is_zero,
  output logic          is_one
);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)     cnt_d = load_val;
    else if (dec) cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= '0;
    else if (load || dec) cnt_q <= cnt_d;
  end

  assign is_zero = (cnt_q == '0);
  assign is_one  = (cnt_q == CW'(1));
endmodule

// File: rtl/rzt_oreg.sv
module rzt_oreg #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop_ready,
  output logic          can_push,
  output logic          vld,
  output logic [DW-1:0] dat
);
  logic vld_q, vld_d;
  logic [DW-1:0] dat_q;

  assign can_push = !vld_q || pop_ready;

  always_comb begin
    vld_d = vld_q;
    if (push)                  vld_d = 1'b1;
    else if (vld_q && pop_ready) vld_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    dat_q <= '0;
    else if (push) dat_q <= push_data;
  end

  assign vld = vld_q;
  assign dat = dat_q;
endmodule

// File: rtl/raster_zero_tail.sv
module raster_zero_tail
  import rzt_pkg::*;
#(
  parameter int PIX_W = 32,
  parameter int W_W   = 12,
  parameter int H_W   = 12,
  parameter int HF_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [W_W-1:0]   img_w,
  input  logic [H_W-1:0]   img_h,
  input  logic [HF_W-1:0]  half_k,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PIX_W-1:0] in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PIX_W-1:0] out_data,
  output logic             done
);
  localparam int LEN_W = W_W + H_W + 1;

  rzt_state_e state_q, state_d;
  logic [W_W-1:0]   w_q;
  logic [HF_W-1:0]  hf_q;
  logic             prm_en;
  logic             done_q, done_d;
  logic             cnt_load, cnt_dec, cnt_zero, cnt_one;
  logic [LEN_W-1:0] cnt_val, frame_len, tail_len;
  logic             push, can_push;
  logic [PIX_W-1:0] push_data;

  assign frame_len = LEN_W'(img_w) * LEN_W'(img_h);
  assign tail_len  = LEN_W'(w_q) * LEN_W'(hf_q) + (LEN_W'(hf_q) << 1) + LEN_W'(1);

  always_comb begin
    state_d   = state_q;
    prm_en    = 1'b0;
    done_d    = 1'b0;
    cnt_load  = 1'b0;
    cnt_dec   = 1'b0;
    cnt_val   = frame_len;
    push      = 1'b0;
    push_data = '0;
    in_ready  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          prm_en   = 1'b1;
          cnt_load = 1'b1;
          cnt_val  = frame_len;
          state_d  = ST_FRAME;
        end
      end
      ST_FRAME: begin
        if (cnt_zero) begin
          cnt_load = 1'b1;
          cnt_val  = tail_len;
          state_d  = ST_TAIL;
        end else begin
          in_ready  = can_push;
          push      = in_valid && can_push;
          push_data = in_data;
          if (push) begin
            if (cnt_one) begin
              cnt_load = 1'b1;
              cnt_val  = tail_len;
              state_d  = ST_TAIL;
            end else begin
              cnt_dec = 1'b1;
            end
          end
        end
      end
      ST_TAIL: begin
        push = can_push;
        if (push) begin
          if (cnt_one) state_d = ST_DRAIN;
          else         cnt_dec = 1'b1;
        end
      end
      ST_DRAIN: begin
        if (out_ready) begin
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_q  <= '0;
      hf_q <= '0;
    end else if (prm_en) begin
      w_q  <= img_w;
      hf_q <= half_k;
    end
  end

  rzt_cnt #(.CW(LEN_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cnt_load),
    .dec      (cnt_dec),
    .load_val (cnt_val),
    .is_zero  (cnt_zero),
    .is_one   (cnt_one)
  );

  rzt_oreg #(.DW(PIX_W)) u_oreg (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .push_data (push_data),
    .pop_ready (out_ready),
    .can_push  (can_push),
    .vld       (out_valid),
    .dat       (out_data)
  );

  assign done = done_q;
endmodule

// File: rtl/rzt_chk.sv
module rzt_chk #(
  parameter int PIX_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [PIX_W-1:0] in_data,
  input logic             out_valid,
  input logic             out_ready,
  input logic [PIX_W-1:0] out_data,
  input logic             done
);
  a_r5_hold_while_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  a_r2_pixel_passes: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_valid && (out_data == $past(in_data))));

  a_r6_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r6_done_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(out_valid && out_ready));

  a_r9_quiet_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!out_valid && !in_ready));
endmodule

bind raster_zero_tail rzt_chk #(.PIX_W(PIX_W)) u_rzt_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_data   (in_data),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .done      (done)
);

// File: tb/raster_zero_tail_bench.sv
module raster_zero_tail_bench;
  localparam int PIX_W = 32;
  localparam int W_W   = 12;
  localparam int H_W   = 12;
  localparam int HF_W  = 3;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic             rst_n, start, in_valid, in_ready, out_valid, out_ready, done;
  logic [W_W-1:0]   img_w;
  logic [H_W-1:0]   img_h;
  logic [HF_W-1:0]  half_k;
  logic [PIX_W-1:0] in_data, out_data;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  logic [15:0] lfsr = 16'hACE1;

  raster_zero_tail #(.PIX_W(PIX_W), .W_W(W_W), .H_W(H_W), .HF_W(HF_W)) u_raster_zero_tail (
    .clk(clk), .rst_n(rst_n), .start(start), .img_w(img_w), .img_h(img_h), .half_k(half_k),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .done(done)
  );

  always @(posedge clk) cyc <= cyc + 1;

  initial begin
    forever begin
      @(posedge clk);
      if (cyc > 150000) begin
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected<=150000", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] pix(input int c, input int i);
    return {8'(32'hC0 ^ c), 8'(i * 3), 8'(i + 1), 8'(c + i)};
  endfunction

  task automatic run_cfg(input int c, input int w, input int h, input int hf, input int thr);
    int nf = w * h;
    int nt = w * hf + 2 * hf + 1;
    int src = 0;
    int got = 0;
    int guard = 0;
    int hold_bad = 0;
    int intake_bad = 0;
    bit seen_done = 0;
    bit hold_pend = 0;
    bit last_acc = 0;
    logic [31:0] hold_d = '0;
    logic [31:0] exp_d;
    @(negedge clk);
    start = 1'b1; img_w = W_W'(w); img_h = H_W'(h); half_k = HF_W'(hf);
    @(negedge clk);
    // R7: parameters scrambled after capture
    img_w = W_W'(w + 3); img_h = H_W'(h + 2); half_k = HF_W'(hf + 1);
    while (!seen_done && guard < 3000) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready = (int'(lfsr[3:0]) < thr);
      in_valid  = (src < nf) && (lfsr[7] || thr == 16);
      in_data   = pix(c, src);
      start     = (guard == 0); // R7: start during a run is ignored
      #1;
      if (done) begin
        seen_done = 1;
        check(got == nf + nt && last_acc, "R6", "done after final accept", got, nf + nt);
      end
      if (hold_pend && !(out_valid && out_data == hold_d)) hold_bad++;
      hold_pend = out_valid && !out_ready;
      hold_d    = out_data;
      if (in_ready && src >= nf) intake_bad++;
      last_acc = 0;
      if (out_valid && out_ready) begin
        exp_d = (got < nf) ? pix(c, got) : 32'h0;
        if (got < nf) check(out_data == exp_d, "R2", "frame pixel", out_data, exp_d);
        else          check(out_data == exp_d, "R3", "zero pixel", out_data, exp_d);
        got++;
        last_acc = (got == nf + nt);
      end
      if (in_valid && in_ready) src++;
      guard++;
      @(negedge clk);
    end
    start = 1'b0;
    in_valid = 1'b0;
    check(seen_done, "R6", "done seen", seen_done, 1);
    check(got == nf + nt, "R3", "output count", got, nf + nt);
    check(hold_bad == 0, "R5", "stalled hold", hold_bad, 0);
    check(intake_bad == 0, "R4", "intake after frame", intake_bad, 0);
    check(src == nf, "R7", "inputs taken", src, nf);
    if (nf == 0) check(src == 0, "R8", "empty frame intake", src, 0);
    for (int k = 0; k < 3; k++) begin
      #1;
      check(!out_valid && !in_ready && !done, "R9", "idle after done",
            {out_valid, in_ready, done}, 0);
      @(negedge clk);
    end
  endtask

  initial begin
    int c = 0;
    rst_n = 1'b0; start = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    img_w = '0; img_h = '0; half_k = '0; in_data = '0;
    repeat (3) @(negedge clk);
    check(!out_valid && !in_ready && !done, "R1", "in reset", {out_valid, in_ready, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid && !in_ready && !done, "R1", "after reset", {out_valid, in_ready, done}, 0);
    for (int w = 0; w <= 4; w++)
      for (int h = 0; h <= 3; h++)
        for (int hf = 0; hf <= 2; hf++) begin
          c++;
          run_cfg(c, w, h, hf, ((w + h + hf) % 3 == 0) ? 16 : (((w + h + hf) % 3 == 1) ? 8 : 12));
        end
    // frame/tail overlap at full throughput, and larger half
    run_cfg(c + 1, 7, 3, 3, 16);
    run_cfg(c + 2, 0, 5, 3, 16);
    run_cfg(c + 3, 6, 0, 2, 5);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule